// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates a 64-bit effective address into a real address by walking a radix page table kept in ordinary memory. A translation request carries the effective address, a process ID, a process-table base word and a problem-state (user) bit. The walker first reads the process-table entry for that process. From that entry it takes the tree size, the root directory base and the root index width. It then reads one 8-byte directory entry per level until it reaches a leaf, or until it hits an invalid entry or the level limit.

Memory is reached through a single-outstanding read port. A request is held with valid until ready is seen, and exactly one 64-bit response is expected later. While a walk is in flight the request side reports not-ready. Each walk ends with a one-cycle result carrying either the real address or a fault code. The real address keeps the page number above the remaining shift and takes the effective-address bits below it, so large leaves placed at upper levels give large pages.

All bit positions below are LSB-0: bit 63 is the most significant bit.

Top module: `radix_walker`

## Requirements
- R1: During reset and after it, with no request pending, `req_ready` is 1 and both `mem_req_valid` and `rsp_valid` are 0.
- R2: The first read goes to the process-table entry at `({prtb[59:12],12'b0} & ~M) | ({pid,4'b0} & M)`, where M has ones in bits below `12 + prtb[4:0]`. This gives 16-byte entries, and process-ID bits above the table size are ignored.
- R3: The process-table entry is decoded as follows. The tree size is `31 + {d[62:61], d[7:5]}`. The root base is `d[59:8]` shifted left by 8. The root index width is `d[4:0]`.
- R4: At each level the shift drops by the index width N. The entry address is `base | (((ea >> shift) & (2^N-1)) << 3)`. A non-leaf directory entry supplies the next base in `d[59:8]` shifted left by 8 and the next N in `d[4:0]`.
- R5: A directory entry with valid bit `d[63]` = 0 ends the walk with fault code 1 and address 0.
- R6: A leaf (`d[63]`=1, `d[62]`=1) whose read-permit bit `d[2]` is 0 ends with fault code 3 and address 0.
- R7: A readable leaf whose privileged-only bit `d[3]` is 1 ends with fault code 4 and address 0 when the request's problem-state bit is 1. It translates normally when that bit is 0.
- R8: A permitted leaf returns fault code 0. The real address has bits 63:56 at 0. Bits 55:12 are the leaf's `d[55:12]` where the remaining-shift mask is 0 and the effective address where it is 1. Bits 11:0 equal the effective address.
- R9: When the directory entry read at the last allowed level (MAX_LVL, default 4) is valid but not a leaf, the walk ends with fault code 2 and address 0. That is MAX_LVL+1 memory reads in total.
- R10: A memory request keeps `mem_req_valid` and `mem_req_addr` stable until accepted by `mem_req_ready`, and its address is 8-byte aligned.
- R11: `rsp_valid` is high for exactly one cycle per request, and `req_ready` is 0 from acceptance until that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_ea | input | 64 | Effective address |
| req_pid | input | PID_W | Process ID |
| req_prtb | input | 64 | Process-table base and size word |
| req_pr | input | 1 | Problem-state (user) bit |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Byte address of the 8-byte read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Read data |
| rsp_valid | output | 1 | Result pulse |
| rsp_addr | output | 64 | Real address (0 on fault) |
| rsp_fault | output | 3 | 0 ok, 1 invalid, 2 too deep, 3 no read, 4 privilege |

## Verification
The assertions rely on the memory returning exactly one response per accepted request, never in the same cycle as the acceptance and never when no read is open. They also rely on index widths never exceeding the remaining shift. The bench memory model answers each accepted read once, two cycles later. It stalls `mem_req_ready` on a repeating pattern so that the hold rule is exercised. All table images are built with index widths that fit inside the tree size.

// File: rtl/rw_pkg.sv
package rw_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_INVALID = 3'd1,
    FLT_DEPTH   = 3'd2,
    FLT_NOREAD  = 3'd3,
    FLT_PRIV    = 3'd4
  } fault_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRT,
    ST_DIR
  } walk_state_t;

  localparam int VALID_BIT = 63;
  localparam int LEAF_BIT  = 62;
  localparam int RD_BIT    = 2;
  localparam int PRIV_BIT  = 3;
endpackage

// File: rtl/rw_mask_gen.sv
module rw_mask_gen #(
  parameter int W    = 64,
  parameter int SH_W = 7
) (
  input  logic [SH_W-1:0] width,
  output logic [W-1:0]    mask
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mask[i] = (SH_W'(i) < width);
  end
endmodule

// File: rtl/rw_next_addr.sv
module rw_next_addr #(
  parameter int SH_W = 7
) (
  input  logic [63:0]     entry,
  input  logic [SH_W-1:0] start_shift,
  input  logic [63:0]     ea,
  output logic [63:0]     next_addr,
  output logic [SH_W-1:0] next_shift
);
  logic [SH_W-1:0] nls;
  logic [63:0]     idx_mask;
  logic [63:0]     idx;

  assign nls        = SH_W'(entry[4:0]);
  assign next_shift = start_shift - nls;

  rw_mask_gen #(.W(64), .SH_W(SH_W)) u_idx_mask (
    .width (nls),
    .mask  (idx_mask)
  );

  assign idx       = (ea >> next_shift) & idx_mask;
  assign next_addr = {4'b0, entry[59:8], 8'b0} | (idx << 3);
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rw_pkg::*;
#(
  parameter int PID_W   = 20,
  parameter int MAX_LVL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [63:0]      req_ea,
  input  logic [PID_W-1:0] req_pid,
  input  logic [63:0]      req_prtb,
  input  logic             req_pr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [63:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  output logic             rsp_valid,
  output logic [63:0]      rsp_addr,
  output logic [2:0]       rsp_fault
);
  localparam int SH_W  = 7;
  localparam int LVL_W = (MAX_LVL > 1) ? $clog2(MAX_LVL) : 1;

  walk_state_t      state;
  logic [63:0]      ea_q;
  logic             pr_q;
  logic [SH_W-1:0]  cur_shift;
  logic [LVL_W-1:0] lvl;

  logic [SH_W-1:0]  mask_w;
  logic [63:0]      mask_a;
  logic [63:0]      prt_addr;
  logic [63:0]      merged;
  logic [SH_W-1:0]  start_shift;
  logic [63:0]      nxt_addr;
  logic [SH_W-1:0]  nxt_shift;

  assign req_ready = (state == ST_IDLE);

  // one mask generator serves both the table-entry address and the leaf merge
  assign mask_w = (state == ST_IDLE) ? SH_W'(12) + SH_W'(req_prtb[4:0]) : cur_shift;

  rw_mask_gen #(.W(64), .SH_W(SH_W)) u_mask (
    .width (mask_w),
    .mask  (mask_a)
  );

  assign prt_addr = ({4'b0, req_prtb[59:12], 12'b0} & ~mask_a)
                  | (64'({req_pid, 4'b0}) & mask_a);
  assign merged   = (mem_rsp_data & ~mask_a) | (ea_q & mask_a);

  assign start_shift = (state == ST_PRT)
                     ? SH_W'(31) + {2'b0, mem_rsp_data[62:61], mem_rsp_data[7:5]}
                     : cur_shift;

  rw_next_addr #(.SH_W(SH_W)) u_next (
    .entry       (mem_rsp_data),
    .start_shift (start_shift),
    .ea          (ea_q),
    .next_addr   (nxt_addr),
    .next_shift  (nxt_shift)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      ea_q          <= '0;
      pr_q          <= 1'b0;
      cur_shift     <= '0;
      lvl           <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      rsp_valid     <= 1'b0;
      rsp_addr      <= '0;
      rsp_fault     <= FLT_NONE;
    end else begin
      rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) mem_req_valid <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          ea_q          <= req_ea;
          pr_q          <= req_pr;
          mem_req_addr  <= prt_addr;
          mem_req_valid <= 1'b1;
          state         <= ST_PRT;
        end
        ST_PRT: if (mem_rsp_valid) begin
          mem_req_addr  <= nxt_addr;
          mem_req_valid <= 1'b1;
          cur_shift     <= nxt_shift;
          lvl           <= '0;
          state         <= ST_DIR;
        end
        ST_DIR: if (mem_rsp_valid) begin
          if (!mem_rsp_data[VALID_BIT] || mem_rsp_data[LEAF_BIT]
              || lvl == LVL_W'(MAX_LVL - 1)) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_addr  <= '0;
            if (!mem_rsp_data[VALID_BIT])      rsp_fault <= FLT_INVALID;
            else if (!mem_rsp_data[LEAF_BIT])  rsp_fault <= FLT_DEPTH;
            else if (!mem_rsp_data[RD_BIT])    rsp_fault <= FLT_NOREAD;
            else if (mem_rsp_data[PRIV_BIT] && pr_q) rsp_fault <= FLT_PRIV;
            else begin
              rsp_fault <= FLT_NONE;
              rsp_addr  <= {8'b0, merged[55:12], ea_q[11:0]};
            end
          end else begin
            mem_req_addr  <= nxt_addr;
            mem_req_valid <= 1'b1;
            cur_shift     <= nxt_shift;
            lvl           <= lvl + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r10_hold_req: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r10_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r11_busy_no_accept: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  a_r5_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault != 3'd0 |-> rsp_addr == 64'd0);

  a_r8_top_byte_clear: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_addr[63:56] == 8'd0);
endmodule

// File: tb/sim_radix_walker.sv
module sim_radix_walker;
  localparam int PID_W = 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [63:0]      req_ea = '0;
  logic [PID_W-1:0] req_pid = '0;
  logic [63:0]      req_prtb = '0;
  logic             req_pr = 1'b0;
  logic             mem_req_valid;
  logic             mem_req_ready;
  logic [63:0]      mem_req_addr;
  logic             mem_rsp_valid;
  logic [63:0]      mem_rsp_data;
  logic             rsp_valid;
  logic [63:0]      rsp_addr;
  logic [2:0]       rsp_fault;

  always #10 clk = ~clk;

  radix_walker #(.PID_W(PID_W), .MAX_LVL(4)) u0 (.*);

  int tests = 0;
  int fails = 0;

  // memory model
  logic [63:0] mem [longint];
  logic        pend;
  int          dly;
  logic [63:0] paddr;
  int          rd_cnt;
  int          cyc;

  always @(posedge clk) begin
    if (rst) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      pend <= 1'b0; dly <= 0; paddr <= '0; rd_cnt <= 0; cyc <= 0;
    end else begin
      cyc           <= cyc + 1;
      mem_req_ready <= (cyc % 3) != 0;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        pend <= 1'b1; dly <= 2; paddr <= mem_req_addr; rd_cnt <= rd_cnt + 1;
      end else if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem.exists(longint'(paddr)) ? mem[longint'(paddr)] : 64'd0;
          pend <= 1'b0;
        end else dly <= dly - 1;
      end
    end
  end

  typedef struct {
    logic [63:0] addr;
    logic [2:0]  fault;
    int          reads;
    string       tag;
  } exp_t;
  exp_t sb [$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic translate(input logic [63:0] ea, input logic [PID_W-1:0] pid,
                           input logic [63:0] prtb, input logic pr,
                           input logic [63:0] ea_exp, input logic [2:0] f_exp,
                           input int reads, input string tag);
    exp_t e;
    e.addr = ea_exp; e.fault = f_exp; e.reads = reads; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_pid = pid; req_prtb = prtb; req_pr = pr;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on every result
  int last_rd = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        if (sb.size() == 0) check(1'b0, "R11 unexpected result", 64'(rsp_fault), 64'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_fault == e.fault, {e.tag, " fault"}, 64'(rsp_fault), 64'(e.fault));
          check(rsp_addr == e.addr, {e.tag, " addr"}, rsp_addr, e.addr);
          check(rd_cnt - last_rd == e.reads, {e.tag, " reads"}, 64'(rd_cnt - last_rd), 64'(e.reads));
        end
        last_rd = rd_cnt;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  localparam logic [63:0] PRTB0 = 64'h0000_0000_0100_0000;
  localparam logic [63:0] PRTB1 = 64'h0000_0000_0100_0001;

  initial begin
    // table images
    mem[64'h1000000] = 64'h0000_0000_0003_000D;   // pid 0: tree 31, root 0x30000, N=13
    mem[64'h30000]   = 64'h8000_0000_0004_0006;   // dir: next 0x40000, N=6
    mem[64'h40008]   = 64'hC000_0000_0500_1004;   // leaf readable
    mem[64'h40018]   = 64'hC000_0000_0700_0000;   // leaf, no read
    mem[64'h40020]   = 64'hC000_0000_0800_000C;   // leaf, privileged only
    mem[64'h1000010] = 64'h0000_0000_0005_000D;   // pid 1: root 0x50000, N=13
    mem[64'h50008]   = 64'hC000_0000_0AB0_0004;   // large leaf at root level
    mem[64'h1000020] = 64'h6000_0000_0006_00E1;   // pid 2: tree 62, root 0x60000, N=1
    mem[64'h60000]   = 64'h8000_0000_0006_0001;   // self-referencing dir
    mem[64'h1001010] = 64'h0000_0000_0003_000D;   // pid 0x101 with 13-bit table

    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
    check(mem_req_valid == 1'b0, "R1 no mem req in reset", 64'(mem_req_valid), 64'd0);
    check(rsp_valid == 1'b0, "R1 no rsp in reset", 64'(rsp_valid), 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(req_ready == 1'b1 && mem_req_valid == 1'b0, "R1 idle after reset", 64'(req_ready), 64'd1);

    translate(64'h1101, 20'd0, PRTB0, 1'b0, 64'h5001101, 3'd0, 3, "R3 R4 R8 4k page");
    translate(64'h1FFF, 20'd0, PRTB0, 1'b1, 64'h5001FFF, 3'd0, 3, "R8 page offset end");
    translate(64'hFF00_0000_0000_1ABC, 20'd0, PRTB0, 1'b0, 64'h5001ABC, 3'd0, 3, "R8 high ea ignored");
    translate(64'h45678, 20'd1, PRTB0, 1'b0, 64'h0AB05678, 3'd0, 2, "R8 large page");
    translate(64'h45678, 20'h101, PRTB0, 1'b0, 64'h0AB05678, 3'd0, 2, "R2 pid masked");
    translate(64'h1101, 20'h101, PRTB1, 1'b0, 64'h5001101, 3'd0, 3, "R2 wider table");
    translate(64'h2000, 20'd0, PRTB0, 1'b0, 64'd0, 3'd1, 3, "R5 invalid entry");
    translate(64'h3000, 20'd0, PRTB0, 1'b0, 64'd0, 3'd3, 3, "R6 no read");
    translate(64'h4ABC, 20'd0, PRTB0, 1'b1, 64'd0, 3'd4, 3, "R7 priv user");
    translate(64'h4ABC, 20'd0, PRTB0, 1'b0, 64'h8000ABC, 3'd0, 3, "R7 priv supervisor");
    translate(64'h0, 20'd2, PRTB0, 1'b0, 64'd0, 3'd2, 5, "R9 depth limit");

    // R11: during a walk, req_ready stays low until the single result pulse
    fork
      translate(64'h1101, 20'd0, PRTB0, 1'b0, 64'h5001101, 3'd0, 3, "R11 walk");
      begin
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        check(req_ready == 1'b0, "R11 busy while walking", 64'(req_ready), 64'd0);
      end
    join
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 pulse one cycle", 64'(rsp_valid), 64'd0);
    check(sb.size() == 0, "R11 all results seen", 64'(sb.size()), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule